// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind a two-wire serial slave front end and handles the write side of a 256-byte nonvolatile store, which is modelled here as a register array. The front end hands over each received data byte with its target address as a one-cycle strobe. The block gathers these bytes in a small page buffer. When the front end reports the end of the transfer with a stop strobe, the block runs a self-timed programming cycle. During that cycle it moves the buffered bytes into the array and holds `busy` high for a fixed number of clock cycles. The front end uses `busy` to withhold acknowledges while programming is in progress.

A page carries up to `PAGE_DEPTH` bytes. If a transfer brings more, the buffer keeps only the newest ones, and each new byte displaces the oldest entry. Two inputs can suppress array writes. With the protect level high, bytes bound for the upper half of the address space are dropped. With the supply-low flag high, no byte is written at all. In both cases the cycle still lasts its full length. A separate read port returns array contents with one cycle of latency and never sees bytes that are still pending in the buffer.

Top module: `eeprom_page_writer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy` and `rd_data` are 0. The page buffer comes out of reset empty.
- R2: `rd_data` shows the array byte at the `rd_addr` sampled on the previous rising edge. Locations that have never been written read 0xFF.
- R3: A `stop_stb` sampled while idle, with at least one byte buffered, raises `busy` on the next cycle. `busy` then stays high for exactly `PROG_CYCLES` cycles, and this length is the same for one byte and for a full page.
- R4: A `stop_stb` sampled while idle with the buffer empty starts no cycle, and `busy` stays 0.
- R5: Buffered bytes reach their addresses by the end of the cycle. Before the stop, a read of such an address returns the old array contents.
- R6: When more than `PAGE_DEPTH` bytes arrive before a stop, only the last `PAGE_DEPTH` bytes are written, and the earliest bytes are discarded.
- R7: Entries are written in arrival order, so when one page writes the same address twice, the later byte is the one that remains.
- R8: While `wp_in` is 1, bytes whose address has bit 7 set (addresses 128 to 255) are dropped and the lower half is still written. The cycle keeps its full length.
- R9: While `wp_in` is 0, upper-half addresses are written normally.
- R10: While `vlow_in` is 1 during a cycle, no array location changes, and `busy` still lasts `PROG_CYCLES` cycles.
- R11: Byte strobes and stop strobes that arrive while `busy` is high are ignored. They neither enter the buffer nor start a new cycle.
- R12: A byte strobe in the same cycle as an idle stop strobe is accepted into the page, and it can be the only byte of that page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle strobe for a received data byte |
| wr_addr | input | 8 | Array address of the byte |
| wr_data | input | 8 | Byte value |
| stop_stb | input | 1 | One-cycle strobe marking the end of a transfer |
| wp_in | input | 1 | Protect level for the upper half of the array |
| vlow_in | input | 1 | Supply-low flag that inhibits all array writes |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High for the whole programming cycle |

## Verification
The bench builds the block with the default `PAGE_DEPTH` of 16 and shortens `PROG_CYCLES` to 40. This keeps every cycle short enough that overlong pages, the protected and low-supply cycles, and strobes arriving during busy can all be driven within a few thousand clocks. Because the page depth stays at its real value, the bench can make overflow displace exactly four entries of a twenty-byte page. Every cycle length is measured against the same 40-cycle figure, whether the cycle wrote one byte, sixteen bytes, or nothing at all.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  localparam int EEPW_ADDR_W = 8;
  localparam int EEPW_DATA_W = 8;

  typedef struct packed {
    logic [EEPW_ADDR_W-1:0] addr;
    logic [EEPW_DATA_W-1:0] data;
  } page_ent_t;

  function automatic logic in_upper_half(input logic [EEPW_ADDR_W-1:0] a);
    return a[EEPW_ADDR_W-1];
  endfunction
endpackage

// File: rtl/eepw_page_buf.sv
module eepw_page_buf
  import eepw_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  page_ent_t                  push_ent,
  input  logic                       pop,
  output page_ent_t                  head,
  output logic                       head_vld,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  page_ent_t         slots [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     rd_ptr;
  logic              full;

  assign full     = (count == CW'(DEPTH));
  assign head     = slots[rd_ptr];
  assign head_vld = vld[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      vld[wr_ptr] <= 1'b1;
      wr_ptr      <= nxt(wr_ptr);
      if (full) rd_ptr <= nxt(rd_ptr);   // oldest entry displaced
      else      count  <= count + 1'b1;
    end else if (pop && count != '0) begin
      vld[rd_ptr] <= 1'b0;
      rd_ptr      <= nxt(rd_ptr);
      count       <= count - 1'b1;
    end
  end
endmodule

// File: rtl/eepw_prog_timer.sv
module eepw_prog_timer #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES+1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        remain <= CW'(CYCLES-1);
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [7:0]  ERASED   = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = DW'(ERASED);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int PAGE_DEPTH  = 16,
  parameter int PROG_CYCLES = 50000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [EEPW_ADDR_W-1:0] wr_addr,
  input  logic [EEPW_DATA_W-1:0] wr_data,
  input  logic                   stop_stb,
  input  logic                   wp_in,
  input  logic                   vlow_in,
  input  logic [EEPW_ADDR_W-1:0] rd_addr,
  output logic [EEPW_DATA_W-1:0] rd_data,
  output logic                   busy
);
  localparam int CNT_W = $clog2(PAGE_DEPTH+1);

  page_ent_t              new_ent;
  page_ent_t              head;
  logic                   head_vld;
  logic [CNT_W-1:0]       buf_cnt;
  logic                   accept;
  logic                   start;
  logic                   drain;
  logic                   blocked;
  logic                   arr_we;

  assign new_ent = '{addr: wr_addr, data: wr_data};
  assign accept  = wr_stb && !busy;
  assign start   = stop_stb && !busy && (wr_stb || buf_cnt != '0);
  assign drain   = busy && buf_cnt != '0;
  assign blocked = vlow_in || (wp_in && in_upper_half(head.addr));
  assign arr_we  = drain && head_vld && !blocked;

  eepw_page_buf #(.DEPTH(PAGE_DEPTH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .push     (accept),
    .push_ent (new_ent),
    .pop      (drain),
    .head     (head),
    .head_vld (head_vld),
    .count    (buf_cnt)
  );

  eepw_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy)
  );

  eepw_array #(.AW(EEPW_ADDR_W), .DW(EEPW_DATA_W)) u_arr (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .waddr (head.addr),
    .wdata (head.data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int PAGE_DEPTH  = 16,
  parameter int PROG_CYCLES = 50000
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_stb,
  input logic                             stop_stb,
  input logic                             wp_in,
  input logic                             vlow_in,
  input logic                             busy,
  input logic [$clog2(PAGE_DEPTH+1)-1:0]  buf_cnt,
  input logic                             arr_we,
  input logic [7:0]                       arr_waddr,
  input logic [7:0]                       rd_data
);
  localparam int RW = $clog2(PROG_CYCLES+2);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!busy && rd_data == '0 && buf_cnt == '0));

  // R3
  cycle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_stb && (wr_stb || buf_cnt != '0)) |=> busy);

  // R3
  cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == RW'(PROG_CYCLES)));

  // R4
  empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_stb && !wr_stb && buf_cnt == '0) |=> !busy);

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    buf_cnt <= ($clog2(PAGE_DEPTH+1))'(PAGE_DEPTH));

  // R8
  protect_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we && wp_in) |-> !arr_waddr[7]);

  // R10
  low_supply_chk: assert property (@(posedge clk) disable iff (rst)
    vlow_in |-> !arr_we);

  // R11
  no_fill_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (buf_cnt <= $past(buf_cnt)));

  // R5
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
endmodule

bind eeprom_page_writer eepw_checker #(
  .PAGE_DEPTH  (PAGE_DEPTH),
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .stop_stb  (stop_stb),
  .wp_in     (wp_in),
  .vlow_in   (vlow_in),
  .busy      (busy),
  .buf_cnt   (buf_cnt),
  .arr_we    (arr_we),
  .arr_waddr (head.addr),
  .rd_data   (rd_data)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int PCYC       = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       stop_stb = 1'b0;
  logic       wp_in = 1'b0;
  logic       vlow_in = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer #(.PAGE_DEPTH(DEPTH), .PROG_CYCLES(PCYC)) i_eeprom_page_writer (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_stb(stop_stb), .wp_in(wp_in), .vlow_in(vlow_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // stop strobe, then measure busy length in cycles
  task automatic stop_and_wait(output int len);
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    len = 0;
    while (busy && len < 4*PCYC) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk_mem(input string req, input logic [7:0] a);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, model[a]);
  endtask

  task automatic t_reset;
    int hi;
    chk("R1 busy in reset", busy, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    rst = 1'b0;
    chk("R1 busy after reset", busy, 0);
    chk("R1 rd_data after reset", rd_data, 0);
    // R4: empty stop right after reset
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      if (busy) hi++;
      @(negedge clk);
    end
    chk("R4 empty stop busy cycles", hi, 0);
  endtask

  task automatic t_erased;
    chk_mem("R2 erased 00", 8'h00);
    chk_mem("R2 erased 7F", 8'h7F);
    chk_mem("R2 erased FF", 8'hFF);
  endtask

  task automatic t_single;
    int len;
    put_byte(8'h10, 8'h5A);
    chk_mem("R5 pending not visible", 8'h10);
    stop_and_wait(len);
    chk("R3 single byte cycle length", len, PCYC);
    model[8'h10] = 8'h5A;
    chk_mem("R5 single byte written", 8'h10);
  endtask

  task automatic t_full_page;
    int len;
    for (int i = 0; i < DEPTH; i++) put_byte(8'(8'h20 + i), 8'(i ^ 8'h30));
    stop_and_wait(len);
    chk("R3 full page cycle length", len, PCYC);
    for (int i = 0; i < DEPTH; i++) begin
      model[8'h20 + i] = 8'(i ^ 8'h30);
      chk_mem("R5 full page byte", 8'(8'h20 + i));
    end
  endtask

  task automatic t_overflow;
    int len;
    for (int i = 0; i < DEPTH + 4; i++) put_byte(8'(8'h40 + i), 8'(8'h80 + i));
    stop_and_wait(len);
    chk("R6 overflow cycle length", len, PCYC);
    for (int i = 4; i < DEPTH + 4; i++) model[8'h40 + i] = 8'(8'h80 + i);
    for (int i = 0; i < DEPTH + 4; i++) chk_mem("R6 overflow keep newest", 8'(8'h40 + i));
  endtask

  task automatic t_dup;
    int len;
    put_byte(8'h60, 8'h11);
    put_byte(8'h60, 8'h22);
    stop_and_wait(len);
    model[8'h60] = 8'h22;
    chk_mem("R7 later byte wins", 8'h60);
  endtask

  task automatic t_protect;
    int len;
    wp_in = 1'b1;
    put_byte(8'h05, 8'hA5);
    put_byte(8'h85, 8'h5A);
    put_byte(8'hFF, 8'h33);
    put_byte(8'h80, 8'h44);
    stop_and_wait(len);
    chk("R8 protected cycle length", len, PCYC);
    model[8'h05] = 8'hA5;
    chk_mem("R8 lower half written", 8'h05);
    chk_mem("R8 addr 85 blocked", 8'h85);
    chk_mem("R8 addr FF blocked", 8'hFF);
    chk_mem("R8 addr 80 blocked", 8'h80);
    wp_in = 1'b0;
    put_byte(8'h85, 8'h77);
    stop_and_wait(len);
    model[8'h85] = 8'h77;
    chk_mem("R9 upper half writable", 8'h85);
  endtask

  task automatic t_low_supply;
    int len;
    vlow_in = 1'b1;
    put_byte(8'h10, 8'hEE);
    put_byte(8'h07, 8'h01);
    stop_and_wait(len);
    vlow_in = 1'b0;
    chk("R10 inhibited cycle length", len, PCYC);
    chk_mem("R10 addr 10 unchanged", 8'h10);
    chk_mem("R10 addr 07 unchanged", 8'h07);
  endtask

  task automatic t_busy_ignore;
    int len;
    int hi;
    put_byte(8'h70, 8'h01);
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    repeat (3) @(negedge clk);
    put_byte(8'h71, 8'h02);
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    len = 5;
    while (busy && len < 4*PCYC) begin
      len++;
      @(negedge clk);
    end
    chk("R11 no extended cycle", len, PCYC);
    model[8'h70] = 8'h01;
    chk_mem("R11 first page written", 8'h70);
    chk_mem("R11 busy byte dropped", 8'h71);
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      if (busy) hi++;
      @(negedge clk);
    end
    chk("R11 buffer stayed empty", hi, 0);
  endtask

  task automatic t_coincident;
    int len;
    wr_stb = 1'b1; wr_addr = 8'h72; wr_data = 8'h9C; stop_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; stop_stb = 1'b0;
    len = 0;
    while (busy && len < 4*PCYC) begin
      len++;
      @(negedge clk);
    end
    chk("R12 coincident cycle length", len, PCYC);
    model[8'h72] = 8'h9C;
    chk_mem("R12 coincident byte written", 8'h72);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    t_erased();
    t_single();
    t_full_page();
    t_overflow();
    t_dup();
    t_protect();
    t_low_supply();
    t_busy_ignore();
    t_coincident();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule